// File: doc/BRIEF.md
# Flash Command Controller

This block sequences commands for a small on-chip flash array, which it holds in internal storage. Software loads a one-page write buffer with full-word writes into the flash address window, then writes a command word to launch a page program, a program-and-lock, a whole-array erase, a region lock or unlock, a change to one general-purpose non-volatile bit, or the setting of the security bit. A status register reports completion, two sticky error flags, the security state, the region locks and the non-volatile bits. An interrupt line follows the ready flag when it is enabled.

The array holds 16 pages of 16 words, and each lock region spans 4 consecutive pages. Every command must carry a key byte, which guards against stray writes. Lock and non-volatile cells are kept in their erased polarity internally and are inverted on readback. A dedicated wipe input clears the whole array, the locks and the non-volatile bits, and finally the security bit. The number of bus wait states can be programmed.

The bus takes one request at a time. A request is sampled on a rising edge, and `bus_ack` pulses for one cycle L edges later, together with `bus_rdata` for a read. The register window is any address with bit 8 set: offset 0 is MODE, 1 is CMD and 2 is STAT, selected by address bits [1:0]. Addresses with bit 8 clear are flash words: bits [7:4] give the page and bits [3:0] give the word.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, STAT reads 0x00000001 (ready only), MODE reads 0, every flash word reads 0xFFFFFFFF, and `irq` is low.
- R2: A write to the flash window with `bus_be` equal to 4'hF stores the data in buffer word addr[3:0]. Any write with a different `bus_be` is dropped, and this applies to register writes too.
- R3: A CMD word is accepted only when bits [31:24] equal 0x5A and the operation code in bits [3:0] lies in 1..8. Otherwise STAT bit 1 (program error) is set, ready stays high and nothing else changes.
- R4: An accepted command clears ready (STAT bit 0), and ready sets again when the command completes. `irq` equals MODE bit 0 ANDed with ready.
- R5: Code 1 programs the page given by CMD bits [11:8] from the buffer. With MODE bit 1 clear, each word of the page becomes the buffer word.
- R6: With MODE bit 1 set, a page program does not erase first, so each word becomes the old word ANDed with the buffer word.
- R7: Code 4 locks and code 5 unlocks the region holding page CMD[11:8] (region = page / 4). STAT bits [7:4] show the regions, with 1 meaning locked. A code 1 or code 2 command aimed at a locked region leaves the array unchanged and sets STAT bit 2 (lock error). Code 2 programs the page and then locks its region.
- R8: Code 3 erases every word to 0xFFFFFFFF. While any region is locked it changes nothing and sets the lock error instead.
- R9: Code 6 sets and code 7 clears the non-volatile bit whose index is in CMD[11:8]. STAT bits [18:16] show the bits, with 1 meaning set. An index of 3 or more sets the program error.
- R10: Reading STAT returns the error flags and then clears both of them.
- R11: Code 8 sets the security flag (STAT bit 3), and no command clears it. Holding `ext_erase` high while the block is idle drops ready, erases every word, then releases all locks and non-volatile bits, and clears the security flag last.
- R12: MODE bits [9:8] set the wait states ws. A register access takes L=1, a flash read takes L=ws+1, and a buffer write takes L=ws+2, except that ws=3 gives L=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Request strobe, one cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 9 | Word address: bit 8 selects the register window |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables; only 4'hF writes take effect |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Completion pulse |
| ext_erase | input | 1 | Full wipe request, including the security bit |
| irq | output | 1 | Ready interrupt |

## Verification
The bench walks a table of commands, including bad keys, unknown codes, locked targets and out-of-range bit indices, and compares the full status word after each one. A design that drops the key check, or that gets the inverted cell polarity wrong, shows the wrong lock or non-volatile bits there. Directed cases target the stages of a no-erase program, which an erasing design would overwrite. They also cover a program into a locked region and an erase-all with a lock held, either of which a careless design would let corrupt the array. They measure the write latency at ws=3, where a naive design adds one cycle too many, and they check that the security flag survives an unlock but falls after a wipe, which also releases all locks and non-volatile bits.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int DW = 32;
  localparam logic [7:0] CMD_KEY = 8'h5A;

  localparam logic [3:0] OP_WPAGE      = 4'd1;
  localparam logic [3:0] OP_WPAGE_LOCK = 4'd2;
  localparam logic [3:0] OP_ERASE_ALL  = 4'd3;
  localparam logic [3:0] OP_LOCK       = 4'd4;
  localparam logic [3:0] OP_UNLOCK     = 4'd5;
  localparam logic [3:0] OP_NVM_SET    = 4'd6;
  localparam logic [3:0] OP_NVM_CLR    = 4'd7;
  localparam logic [3:0] OP_SEC        = 4'd8;

  localparam logic [1:0] REG_MODE = 2'd0;
  localparam logic [1:0] REG_CMD  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_PROG, SQ_ERALL, SQ_WIPE, SQ_WIPE_BITS, SQ_WIPE_SEC, SQ_FIN
  } sq_e;

  // Cycles from the sampling edge to the acknowledging edge.
  function automatic logic [2:0] fcc_latency(logic is_reg, logic we, logic [1:0] ws);
    if (is_reg) return 3'd1;
    if (!we) return 3'd1 + {1'b0, ws};
    if (ws == 2'd3) return 3'd4;
    return 3'd2 + {1'b0, ws};
  endfunction

  // Programming can only pull bits low unless the page was erased first.
  function automatic logic [DW-1:0] fcc_prog_word(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                                  logic keep_old);
    return keep_old ? (old_w & new_w) : new_w;
  endfunction

  function automatic logic fcc_op_known(logic [3:0] op);
    return (op != 4'd0) && (op <= OP_SEC);
  endfunction
endpackage

// File: rtl/fcc_bus_timer.sv
module fcc_bus_timer
  import fcc_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [3:0]    be,
  input  logic [1:0]    ws,
  output logic          xfer,
  output logic          x_we,
  output logic [AW-1:0] x_addr,
  output logic [DW-1:0] x_wdata,
  output logic [3:0]    x_be
);
  logic       pend;
  logic [2:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      cnt     <= '0;
      x_we    <= 1'b0;
      x_addr  <= '0;
      x_wdata <= '0;
      x_be    <= '0;
    end else if (pend) begin
      if (cnt == 3'd0) pend <= 1'b0;
      else cnt <= cnt - 3'd1;
    end else if (req) begin
      pend    <= 1'b1;
      cnt     <= fcc_latency(addr[AW-1], we, ws) - 3'd1;
      x_we    <= we;
      x_addr  <= addr;
      x_wdata <= wdata;
      x_be    <= be;
    end
  end

  assign xfer = pend && (cnt == 3'd0);
endmodule

// File: rtl/fcc_store.sv
module fcc_store
  import fcc_pkg::*;
#(
  parameter int WPP   = 16,
  parameter int PAGES = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bw_en,
  input  logic [$clog2(WPP)-1:0]            bw_idx,
  input  logic [DW-1:0]                     bw_data,
  input  logic [$clog2(WPP)-1:0]            br_idx,
  output logic [DW-1:0]                     br_data,
  input  logic                              aw_en,
  input  logic [$clog2(PAGES*WPP)-1:0]      aw_addr,
  input  logic [DW-1:0]                     aw_data,
  input  logic [$clog2(PAGES*WPP)-1:0]      ra_addr,
  output logic [DW-1:0]                     ra_data,
  input  logic [$clog2(PAGES*WPP)-1:0]      rb_addr,
  output logic [DW-1:0]                     rb_data
);
  localparam int WORDS = PAGES * WPP;

  logic [DW-1:0] pbuf [WPP];
  logic [DW-1:0] mem  [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WPP; i++) pbuf[i] <= '1;
    end else if (bw_en) begin
      pbuf[bw_idx] <= bw_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (aw_en) begin
      mem[aw_addr] <= aw_data;
    end
  end

  assign br_data = pbuf[br_idx];
  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
  import fcc_pkg::*;
#(
  parameter int WPP   = 16,
  parameter int PAGES = 16,
  parameter int PPR   = 4,
  parameter int NVM_N = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cmd_wr,
  input  logic [7:0]                         cmd_key,
  input  logic [3:0]                         cmd_op,
  input  logic [$clog2(PAGES)-1:0]           cmd_arg,
  input  logic                               no_erase,
  input  logic                               ext_erase,
  input  logic                               stat_rd,
  input  logic [DW-1:0]                      rb_data,
  input  logic [DW-1:0]                      br_data,
  output logic [$clog2(PAGES*WPP)-1:0]       rb_addr,
  output logic [$clog2(WPP)-1:0]             br_idx,
  output logic                               aw_en,
  output logic [$clog2(PAGES*WPP)-1:0]       aw_addr,
  output logic [DW-1:0]                      aw_data,
  output logic                               ready,
  output logic                               perr,
  output logic                               lerr,
  output logic                               sec,
  output logic [PAGES/PPR-1:0]               lock_cells,
  output logic [NVM_N-1:0]                   nvm_cells,
  output logic                               ev_accept,
  output logic                               ev_reject,
  output logic                               ev_sec_clr,
  output logic                               ev_wiping
);
  localparam int WIDX_W  = $clog2(WPP);
  localparam int PAGE_W  = $clog2(PAGES);
  localparam int FA_W    = PAGE_W + WIDX_W;
  localparam int REGIONS = PAGES / PPR;
  localparam int RG_W    = $clog2(REGIONS);
  localparam int NV_W    = (NVM_N > 1) ? $clog2(NVM_N) : 1;

  sq_e               state;
  logic [FA_W-1:0]   idx;
  logic [PAGE_W-1:0] pg;
  logic              lock_after;

  logic            idle, cmd_take, cmd_valid, nvm_op, nvm_ok, arg_locked, any_locked, lock_block;
  logic [RG_W-1:0] arg_region;
  logic [NV_W-1:0] nvm_idx;

  assign idle       = (state == SQ_IDLE);
  assign nvm_op     = (cmd_op == OP_NVM_SET) || (cmd_op == OP_NVM_CLR);
  assign nvm_ok     = (32'(cmd_arg) < NVM_N);
  assign nvm_idx    = cmd_arg[NV_W-1:0];
  assign cmd_valid  = (cmd_key == CMD_KEY) && fcc_op_known(cmd_op) && (!nvm_op || nvm_ok);
  assign cmd_take   = cmd_wr && idle && !ext_erase;
  assign ev_accept  = cmd_take && cmd_valid;
  assign ev_reject  = cmd_take && !cmd_valid;
  assign arg_region = cmd_arg[PAGE_W-1 -: RG_W];
  assign arg_locked = !lock_cells[arg_region];
  assign any_locked = !(&lock_cells);
  assign lock_block = ((cmd_op == OP_WPAGE || cmd_op == OP_WPAGE_LOCK) && arg_locked)
                   || ((cmd_op == OP_ERASE_ALL) && any_locked);

  assign ev_sec_clr = (state == SQ_WIPE_SEC);
  assign ev_wiping  = (state == SQ_WIPE);

  assign br_idx  = idx[WIDX_W-1:0];
  assign rb_addr = {pg, idx[WIDX_W-1:0]};
  assign aw_en   = (state == SQ_PROG) || (state == SQ_ERALL) || (state == SQ_WIPE);
  assign aw_addr = (state == SQ_PROG) ? {pg, idx[WIDX_W-1:0]} : idx;
  assign aw_data = (state == SQ_PROG) ? fcc_prog_word(rb_data, br_data, no_erase) : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      idx        <= '0;
      pg         <= '0;
      lock_after <= 1'b0;
      ready      <= 1'b1;
      perr       <= 1'b0;
      lerr       <= 1'b0;
      sec        <= 1'b0;
      lock_cells <= '1;
      nvm_cells  <= '1;
    end else begin
      if (stat_rd) begin
        perr <= 1'b0;
        lerr <= 1'b0;
      end
      case (state)
        SQ_IDLE: begin
          if (ext_erase) begin
            state <= SQ_WIPE;
            idx   <= '0;
            ready <= 1'b0;
          end else if (ev_reject) begin
            perr <= 1'b1;
          end else if (ev_accept) begin
            ready <= 1'b0;
            state <= SQ_FIN;
            if (lock_block) begin
              lerr <= 1'b1;
            end else begin
              case (cmd_op)
                OP_WPAGE, OP_WPAGE_LOCK: begin
                  state      <= SQ_PROG;
                  idx        <= '0;
                  pg         <= cmd_arg;
                  lock_after <= (cmd_op == OP_WPAGE_LOCK);
                end
                OP_ERASE_ALL: begin
                  state <= SQ_ERALL;
                  idx   <= '0;
                end
                OP_LOCK:    lock_cells[arg_region] <= 1'b0;
                OP_UNLOCK:  lock_cells[arg_region] <= 1'b1;
                OP_NVM_SET: nvm_cells[nvm_idx]     <= 1'b0;
                OP_NVM_CLR: nvm_cells[nvm_idx]     <= 1'b1;
                default:    sec                    <= 1'b1;
              endcase
            end
          end
        end
        SQ_PROG: begin
          idx <= idx + 1'b1;
          if (idx[WIDX_W-1:0] == WIDX_W'(WPP - 1)) begin
            if (lock_after) lock_cells[pg[PAGE_W-1 -: RG_W]] <= 1'b0;
            state <= SQ_FIN;
          end
        end
        SQ_ERALL: begin
          idx <= idx + 1'b1;
          if (idx == FA_W'(PAGES * WPP - 1)) state <= SQ_FIN;
        end
        SQ_WIPE: begin
          idx <= idx + 1'b1;
          if (idx == FA_W'(PAGES * WPP - 1)) state <= SQ_WIPE_BITS;
        end
        SQ_WIPE_BITS: begin
          lock_cells <= '1;
          nvm_cells  <= '1;
          state      <= SQ_WIPE_SEC;
        end
        SQ_WIPE_SEC: begin
          sec   <= 1'b0;
          state <= SQ_FIN;
        end
        default: begin
          ready <= 1'b1;
          state <= SQ_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int WORDS_PER_PAGE   = 16,
  parameter int PAGES            = 16,
  parameter int PAGES_PER_REGION = 4,
  parameter int NVM_BITS         = 3
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    bus_req,
  input  logic                                    bus_we,
  input  logic [$clog2(PAGES*WORDS_PER_PAGE):0]   bus_addr,
  input  logic [31:0]                             bus_wdata,
  input  logic [3:0]                              bus_be,
  output logic [31:0]                             bus_rdata,
  output logic                                    bus_ack,
  input  logic                                    ext_erase,
  output logic                                    irq
);
  localparam int WIDX_W  = $clog2(WORDS_PER_PAGE);
  localparam int PAGE_W  = $clog2(PAGES);
  localparam int FA_W    = PAGE_W + WIDX_W;
  localparam int AW      = FA_W + 1;
  localparam int REGIONS = PAGES / PAGES_PER_REGION;
  localparam int RG_W    = $clog2(REGIONS);
  localparam int STAT_LOCK_LSB = 4;
  localparam int STAT_NVM_LSB  = 16;

  logic            xfer, x_we;
  logic [AW-1:0]   x_addr;
  logic [DW-1:0]   x_wdata;
  logic [3:0]      x_be;
  logic            x_is_reg, x_full;

  logic            irq_en, no_erase;
  logic [1:0]      ws;

  logic            bw_en, cmd_wr, mode_wr, stat_rd;
  logic [WIDX_W-1:0] br_idx;
  logic [DW-1:0]   br_data, ra_data, rb_data, aw_data, stat_word, rd_mux;
  logic [FA_W-1:0] rb_addr, aw_addr;
  logic            aw_en;

  logic            sq_ready, sq_perr, sq_lerr, sq_sec;
  logic [REGIONS-1:0]  lock_cells;
  logic [NVM_BITS-1:0] nvm_cells;
  logic            ev_accept, ev_reject, ev_sec_clr, ev_wiping, ev_aw_locked;
  logic            unused_wbits;

  fcc_bus_timer #(.AW(AW)) u_timer (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .be(bus_be), .ws(ws), .xfer(xfer), .x_we(x_we),
    .x_addr(x_addr), .x_wdata(x_wdata), .x_be(x_be)
  );

  assign x_is_reg = x_addr[AW-1];
  assign x_full   = &x_be;
  assign bw_en    = xfer && x_we && !x_is_reg && x_full;
  assign cmd_wr   = xfer && x_we && x_is_reg && x_full && (x_addr[1:0] == REG_CMD);
  assign mode_wr  = xfer && x_we && x_is_reg && x_full && (x_addr[1:0] == REG_MODE);
  assign stat_rd  = xfer && !x_we && x_is_reg && (x_addr[1:0] == REG_STAT);
  assign unused_wbits = ^{x_wdata[23:8+PAGE_W], x_wdata[7:4]};

  fcc_store #(.WPP(WORDS_PER_PAGE), .PAGES(PAGES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .bw_en(bw_en), .bw_idx(x_addr[WIDX_W-1:0]), .bw_data(x_wdata),
    .br_idx(br_idx), .br_data(br_data),
    .aw_en(aw_en), .aw_addr(aw_addr), .aw_data(aw_data),
    .ra_addr(x_addr[FA_W-1:0]), .ra_data(ra_data),
    .rb_addr(rb_addr), .rb_data(rb_data)
  );

  fcc_seq #(.WPP(WORDS_PER_PAGE), .PAGES(PAGES), .PPR(PAGES_PER_REGION), .NVM_N(NVM_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_key(x_wdata[31:24]),
    .cmd_op(x_wdata[3:0]), .cmd_arg(x_wdata[8 +: PAGE_W]), .no_erase(no_erase),
    .ext_erase(ext_erase), .stat_rd(stat_rd), .rb_data(rb_data), .br_data(br_data),
    .rb_addr(rb_addr), .br_idx(br_idx), .aw_en(aw_en), .aw_addr(aw_addr),
    .aw_data(aw_data), .ready(sq_ready), .perr(sq_perr), .lerr(sq_lerr), .sec(sq_sec),
    .lock_cells(lock_cells), .nvm_cells(nvm_cells), .ev_accept(ev_accept),
    .ev_reject(ev_reject), .ev_sec_clr(ev_sec_clr), .ev_wiping(ev_wiping)
  );

  assign ev_aw_locked = aw_en && !lock_cells[aw_addr[FA_W-1 -: RG_W]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en   <= 1'b0;
      no_erase <= 1'b0;
      ws       <= 2'd0;
    end else if (mode_wr) begin
      irq_en   <= x_wdata[0];
      no_erase <= x_wdata[1];
      ws       <= x_wdata[9:8];
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[0] = sq_ready;
    stat_word[1] = sq_perr;
    stat_word[2] = sq_lerr;
    stat_word[3] = sq_sec;
    stat_word[STAT_LOCK_LSB +: REGIONS] = ~lock_cells;
    stat_word[STAT_NVM_LSB +: NVM_BITS] = ~nvm_cells;
  end

  always_comb begin
    rd_mux = '0;
    if (!x_is_reg) begin
      rd_mux = ra_data;
    end else begin
      case (x_addr[1:0])
        REG_MODE: begin
          rd_mux[0]   = irq_en;
          rd_mux[1]   = no_erase;
          rd_mux[9:8] = ws;
        end
        REG_STAT: rd_mux = stat_word;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= xfer;
      if (xfer && !x_we) bus_rdata <= rd_mux;
    end
  end

  assign irq = irq_en && sq_ready;
endmodule

// File: rtl/fcc_chk.sv
module fcc_chk #(
  parameter int REGIONS = 4,
  parameter int NVM_N   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ready,
  input logic               perr,
  input logic               lerr,
  input logic               sec,
  input logic               stat_rd,
  input logic               ev_accept,
  input logic               ev_reject,
  input logic               ev_sec_clr,
  input logic               ev_wiping,
  input logic               ev_aw_locked,
  input logic [REGIONS-1:0] lock_cells,
  input logic [NVM_N-1:0]   nvm_cells
);
  // R3
  reject_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (perr && ready));

  // R4
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !ready);

  // R7
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_aw_locked |-> ev_wiping);

  // R10
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (!perr && !lerr));

  // R11
  sec_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec) |-> $past(ev_sec_clr));

  // R11
  wipe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sec_clr |-> ((&lock_cells) && (&nvm_cells)));
endmodule

bind flash_cmd_ctrl fcc_chk #(.REGIONS(REGIONS), .NVM_N(NVM_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(sq_ready), .perr(sq_perr), .lerr(sq_lerr),
  .sec(sq_sec), .stat_rd(stat_rd), .ev_accept(ev_accept), .ev_reject(ev_reject),
  .ev_sec_clr(ev_sec_clr), .ev_wiping(ev_wiping), .ev_aw_locked(ev_aw_locked),
  .lock_cells(lock_cells), .nvm_cells(nvm_cells)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, ext_erase = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack, irq;

  int checks = 0, errors = 0;
  logic [31:0] r;
  int lat;

  localparam logic [8:0] A_MODE = 9'h100, A_CMD = 9'h101, A_STAT = 9'h102;

  // {command word, expected STAT after it}
  localparam logic [63:0] VEC [13] = '{
    {32'h5A000104, 32'h00000011},  // R7 lock region 0
    {32'hA5000104, 32'h00000013},  // R3 bad key
    {32'h5A00000C, 32'h00000013},  // R3 unknown code
    {32'h5A000003, 32'h00000015},  // R8 erase-all refused
    {32'h5A000105, 32'h00000001},  // R7 unlock
    {32'h5A000206, 32'h00040001},  // R9 set bit 2
    {32'h5A000306, 32'h00040003},  // R9 index out of range
    {32'h5A000207, 32'h00000001},  // R9 clear bit 2
    {32'h5A000C04, 32'h00000081},  // R7 lock region 3
    {32'h5A000C01, 32'h00000085},  // R7 write into locked region
    {32'h5A000C05, 32'h00000001},  // R7 unlock region 3
    {32'h5A000006, 32'h00010001},  // R9 set bit 0
    {32'h5A000007, 32'h00000001}   // R9 clear bit 0
  };

  flash_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .ext_erase(ext_erase), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [8:0] a, input logic [31:0] d,
                      input logic [3:0] be, output logic [31:0] rd, output int n);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_req = 1'b0;
    n = 1;
    while (!bus_ack) begin
      @(negedge clk);
      n++;
    end
    rd = bus_rdata;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    logic [31:0] t; int k;
    xfer(1'b1, a, d, 4'hF, t, k);
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v);
    int k;
    xfer(1'b0, a, 32'h0, 4'h0, v, k);
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!irq) @(negedge clk);
  endtask

  task automatic cmd(input logic [31:0] w);
    wr(A_CMD, w);
    wait_ready();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_STAT, r); chk("R1 stat", r, 32'h00000001);
    rd(A_MODE, r); chk("R1 mode", r, 32'h0);
    rd(9'h000, r); chk("R1 word0", r, 32'hFFFFFFFF);
    rd(9'h0FF, r); chk("R1 word255", r, 32'hFFFFFFFF);
    wr(A_MODE, 32'h1);

    // Table of commands and expected status
    for (int i = 0; i < 13; i++) begin
      cmd(VEC[i][63:32]);
      rd(A_STAT, r);
      chk($sformatf("R3/R7/R8/R9 vec%0d", i), r, VEC[i][31:0]);
    end

    // R2 R5 program page 3
    for (int i = 0; i < 16; i++) wr(9'(i), 32'hC3C30000 | i);
    wr(A_CMD, 32'h5A000301);
    chk("R4 ready low while busy", {31'b0, irq}, 32'h0);
    wait_ready();
    rd(9'd53, r); chk("R5 word53", r, 32'hC3C30005);
    rd(9'd63, r); chk("R5 word63", r, 32'hC3C3000F);
    rd(9'd64, r); chk("R5 page4 untouched", r, 32'hFFFFFFFF);

    // R2 partial-byte write dropped
    xfer(1'b1, 9'd5, 32'h0, 4'h3, r, lat);
    cmd(32'h5A000301);
    rd(9'd53, r); chk("R2 partial write dropped", r, 32'hC3C30005);

    // R6 no-erase staging
    wr(A_MODE, 32'h3);
    wr(9'd0, 32'h0FFFFFFF);
    cmd(32'h5A000301);
    rd(9'd48, r); chk("R6 word48 AND", r, 32'h03C30000);
    rd(9'd49, r); chk("R6 word49 kept", r, 32'hC3C30001);

    // R5 erase mode again
    wr(A_MODE, 32'h1);
    wr(9'd0, 32'h12345678);
    cmd(32'h5A000301);
    rd(9'd48, r); chk("R5 word48 replaced", r, 32'h12345678);

    // R7 R8 lock protection
    cmd(32'h5A000004);
    wr(9'd0, 32'h0);
    cmd(32'h5A000301);
    rd(A_STAT, r); chk("R7 lock error", r, 32'h00000015);
    rd(9'd48, r); chk("R7 locked page kept", r, 32'h12345678);
    cmd(32'h5A000502);
    rd(9'd80, r); chk("R7 program-and-lock data", r, 32'h0);
    rd(A_STAT, r); chk("R7 program-and-lock status", r, 32'h00000031);
    cmd(32'h5A000003);
    rd(A_STAT, r); chk("R8 refused status", r, 32'h00000035);
    rd(9'd48, r); chk("R8 refused data", r, 32'h12345678);
    cmd(32'h5A000005);
    cmd(32'h5A000405);
    cmd(32'h5A000003);
    rd(A_STAT, r); chk("R8 erase status", r, 32'h00000001);
    rd(9'd48, r); chk("R8 word48 erased", r, 32'hFFFFFFFF);
    rd(9'd80, r); chk("R8 word80 erased", r, 32'hFFFFFFFF);

    // R10 clear on read
    cmd(32'h00000001);
    rd(A_STAT, r); chk("R10 first read", r, 32'h00000003);
    rd(A_STAT, r); chk("R10 second read", r, 32'h00000001);

    // R12 wait states
    for (int w = 0; w < 4; w++) begin
      wr(A_MODE, 32'h1 | (w << 8));
      xfer(1'b0, 9'd10, 32'h0, 4'h0, r, lat);
      chk($sformatf("R12 read ws%0d", w), 32'(lat), 32'(w + 2));
      xfer(1'b1, 9'd10, 32'hFFFFFFFF, 4'hF, r, lat);
      chk($sformatf("R12 write ws%0d", w), 32'(lat), (w == 3) ? 32'd5 : 32'(w + 3));
      xfer(1'b0, A_STAT, 32'h0, 4'h0, r, lat);
      chk($sformatf("R12 reg ws%0d", w), 32'(lat), 32'd2);
    end
    wr(A_MODE, 32'h1);

    // R11 security and wipe
    cmd(32'h5A000701);
    cmd(32'h5A000804);
    cmd(32'h5A000106);
    cmd(32'h5A000008);
    rd(A_STAT, r); chk("R11 secure set", r, 32'h00020049);
    cmd(32'h5A000805);
    rd(A_STAT, r); chk("R11 secure survives unlock", r, 32'h00020009);
    cmd(32'h5A000804);
    @(negedge clk); ext_erase = 1'b1;
    @(negedge clk); ext_erase = 1'b0;
    chk("R11 busy during wipe", {31'b0, irq}, 32'h0);
    while (!irq) @(negedge clk);
    rd(A_STAT, r); chk("R11 wipe status", r, 32'h00000001);
    rd(9'd112, r); chk("R11 wipe data", r, 32'hFFFFFFFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule